// File: doc/BRIEF.md
# I2C Target Address Decoder and Byte Receiver

This block is the receive front end of an I2C target. It samples the SCL and SDA wires with the system clock and passes both through synchronising flops. It finds start and stop conditions and keeps a bus-busy state between them. After each start it shifts in the first byte, which is a 7-bit address followed by a direction bit. The address is checked against a programmable own address and against the reserved codes.

When the block accepts an address, it pulls SDA low through an open-drain enable for the ninth clock pulse. It also gives a one-cycle match strobe, the transfer direction and, for the general call, an indication. If the master writes, each following byte is presented with a one-cycle valid strobe and then acknowledged. Read transfers and address forms it does not accept leave the line released until the next start or stop.

Top module: `i2c_target_rx`

## Requirements
- R1: A falling SDA while SCL is high (a start) sets `bus_busy` one cycle after the condition reaches the synchronised samples.
- R2: A rising SDA while SCL is high (a stop) clears `bus_busy` and returns the receiver to idle.
- R3: The first byte after a start is taken MSB first: bits 7..1 are the address and bit 0 is the direction (0 = master writes, 1 = master reads). When the address equals `own_addr`, `addr_hit` pulses for one cycle and `rw_dir` takes the direction bit.
- R4: An accepted byte is acknowledged by raising `sda_pull` at the SCL falling edge after the eighth bit and dropping it at the next SCL falling edge. `sda_pull` only rises while SCL is low.
- R5: Address 0000000 (the general call) is acknowledged, with `addr_hit` and `gen_call` set, only when `gc_ack_en` is 1. When `gc_ack_en` is 0 it is not acknowledged.
- R6: Address 0000001 is never acknowledged, whatever `gc_ack_en` is.
- R7: An address of the form 1111xxx sets `ext10_flag` and is never acknowledged.
- R8: In a write transfer, each further byte appears on `rx_data` (MSB first) with a one-cycle `rx_valid` and is acknowledged. Any number of bytes may follow.
- R9: A start seen while the bus is busy (a repeated start) restarts address reception at once.
- R10: After an accepted read address the block raises no `rx_valid` and does not pull SDA while the master clocks further bits.
- R11: After reset `bus_busy`, `sda_pull`, `rx_valid`, `addr_hit`, `gen_call`, `ext10_flag` and `rw_dir` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| own_addr | input | 7 | Programmable target address (non-reserved) |
| gc_ack_en | input | 1 | Allows the general call to be acknowledged |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| bus_busy | output | 1 | High between a start and the next stop |
| addr_hit | output | 1 | One-cycle strobe for an accepted address |
| rw_dir | output | 1 | Direction bit of the accepted address |
| gen_call | output | 1 | Accepted address was the general call |
| ext10_flag | output | 1 | Address byte carried the 10-bit extension prefix |
| rx_data | output | 8 | Last received write byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |

## Verification
The assertions assume that every SCL phase lasts several system clocks. They also assume that SDA moves while SCL is high only to form a start or a stop, and that `gc_ack_en` is steady while an address byte is being clocked. The stimulus meets these conditions with a bus model that holds each SCL phase for at least four clocks. It moves SDA only in the middle of the low phase and wires the block's pull-down to SDA as a wired-AND. It changes `gc_ack_en` only while the bus is idle.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
   localparam int ADDR_BITS = 7;
   localparam int BYTE_BITS = ADDR_BITS + 1;

   typedef enum logic [2:0] {
      RX_IDLE, RX_ADDR, RX_ACKWAIT, RX_ACKDRIVE, RX_DATA, RX_SKIP
   } rx_state_t;

   typedef enum logic [2:0] {
      CLS_MINE, CLS_GENCALL, CLS_NULL, CLS_EXT, CLS_OTHER
   } addr_cls_t;

   function automatic addr_cls_t classify(input logic [ADDR_BITS-1:0] a,
                                          input logic [ADDR_BITS-1:0] mine);
      if (a == '0)                 return CLS_GENCALL;
      else if (a == 7'd1)          return CLS_NULL;
      else if (a[6:3] == 4'hF)     return CLS_EXT;
      else if (a == mine)          return CLS_MINE;
      else                         return CLS_OTHER;
   endfunction
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("i2ct_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '1;
            else if (s == 0) chain[s] <= d;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2ct_cond.sv
module i2ct_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic start_det,
   output logic stop_det,
   output logic scl_rise,
   output logic scl_fall,
   output logic busy
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign start_det = scl_p & scl_s & sda_p & ~sda_s;
   assign stop_det  = scl_p & scl_s & ~sda_p & sda_s;
   assign scl_rise  = ~scl_p & scl_s;
   assign scl_fall  = scl_p & ~scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy <= 1'b0;
      else if (start_det) busy <= 1'b1;
      else if (stop_det)  busy <= 1'b0;
   end

   a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> busy);
   a_r2_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !busy);
endmodule

// File: rtl/i2ct_rx.sv
module i2ct_rx
   import i2ct_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_s,
   input  logic                 sda_s,
   input  logic                 start_det,
   input  logic                 stop_det,
   input  logic                 scl_rise,
   input  logic                 scl_fall,
   input  logic [ADDR_BITS-1:0] own_addr,
   input  logic                 gc_ack_en,
   output logic                 sda_pull,
   output logic                 addr_hit,
   output logic                 rw_dir,
   output logic                 gen_call,
   output logic                 ext10_flag,
   output logic [BYTE_BITS-1:0] rx_data,
   output logic                 rx_valid
);
   rx_state_t            st;
   logic [2:0]           cnt;
   logic [BYTE_BITS-1:0] sh;
   logic                 go_data;
   logic [BYTE_BITS-1:0] sh_nx;
   addr_cls_t            cls;
   logic                 take;

   assign sh_nx = {sh[BYTE_BITS-2:0], sda_s};
   assign cls   = classify(sh_nx[BYTE_BITS-1:1], own_addr);
   assign take  = (cls == CLS_MINE) || ((cls == CLS_GENCALL) && gc_ack_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= RX_IDLE; cnt <= '0; sh <= '0; go_data <= 1'b0;
         addr_hit <= 1'b0; rw_dir <= 1'b0; gen_call <= 1'b0;
         ext10_flag <= 1'b0; rx_data <= '0; rx_valid <= 1'b0;
      end else begin
         addr_hit <= 1'b0;
         rx_valid <= 1'b0;
         if (stop_det) begin
            st <= RX_IDLE;
         end else if (start_det) begin
            st <= RX_ADDR; cnt <= '0;
            rw_dir <= 1'b0; gen_call <= 1'b0; ext10_flag <= 1'b0;
         end else begin
            case (st)
               RX_ADDR, RX_DATA: if (scl_rise) begin
                  sh  <= sh_nx;
                  cnt <= cnt + 3'd1;
                  if (cnt == 3'd7) begin
                     if (st == RX_ADDR) begin
                        ext10_flag <= (cls == CLS_EXT);
                        if (take) begin
                           addr_hit <= 1'b1;
                           rw_dir   <= sh_nx[0];
                           gen_call <= (cls == CLS_GENCALL);
                           go_data  <= ~sh_nx[0];
                           st       <= RX_ACKWAIT;
                        end else begin
                           st <= RX_SKIP;
                        end
                     end else begin
                        rx_data  <= sh_nx;
                        rx_valid <= 1'b1;
                        go_data  <= 1'b1;
                        st       <= RX_ACKWAIT;
                     end
                  end
               end
               RX_ACKWAIT: if (scl_fall) st <= RX_ACKDRIVE;
               RX_ACKDRIVE: if (scl_fall) begin
                  st  <= go_data ? RX_DATA : RX_SKIP;
                  cnt <= '0;
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_pull = (st == RX_ACKDRIVE);

   a_r4_pull_starts_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> !scl_s);
   a_r3_hit_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      addr_hit |=> !addr_hit);
   a_r8_valid_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   a_r10_no_data_when_read: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !rw_dir);
   a_r7_ext_never_acked: assert property (@(posedge clk) disable iff (!rst_n)
      ext10_flag |-> !sda_pull);
   a_r5_gc_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gen_call) |-> $past(gc_ack_en));
endmodule

// File: rtl/i2c_target_rx.sv
module i2c_target_rx #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [6:0] own_addr,
   input  logic       gc_ack_en,
   output logic       sda_pull,
   output logic       bus_busy,
   output logic       addr_hit,
   output logic       rw_dir,
   output logic       gen_call,
   output logic       ext10_flag,
   output logic [7:0] rx_data,
   output logic       rx_valid
);
   logic scl_s, sda_s;
   logic start_det, stop_det, scl_rise, scl_fall;

   i2ct_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s}));

   i2ct_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .start_det(start_det), .stop_det(stop_det),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .busy(bus_busy));

   i2ct_rx u_rx (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .start_det(start_det), .stop_det(stop_det),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .own_addr(own_addr), .gc_ack_en(gc_ack_en),
      .sda_pull(sda_pull), .addr_hit(addr_hit), .rw_dir(rw_dir),
      .gen_call(gen_call), .ext10_flag(ext10_flag),
      .rx_data(rx_data), .rx_valid(rx_valid));
endmodule

// File: tb/i2c_target_rx_test.sv
module i2c_target_rx_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [6:0] OWN = 7'h52;
   // fields: [20:13] first byte, [12:5] data byte, [4] gc enable,
   // [3] expect address ack, [2] expect gen_call, [1] expect ext10, [0] expect read
   localparam logic [20:0] VEC [7] = '{
      {8'hA4, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
      {8'hA6, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h00, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
      {8'h00, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h02, 8'h11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'hF4, 8'h22, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
      {8'hA5, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}
   };

   logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, gc_en = 1'b0;
   logic sda_pull, bus_busy, addr_hit, rw_dir, gen_call, ext10_flag, rx_valid;
   logic [7:0] rx_data;
   wire sda_line = sda_m & ~sda_pull;
   int n_chk = 0, n_fail = 0, n_valid = 0, n_hit = 0;
   logic [7:0] got [16];

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_target_rx uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .own_addr(OWN), .gc_ack_en(gc_en), .sda_pull(sda_pull),
      .bus_busy(bus_busy), .addr_hit(addr_hit), .rw_dir(rw_dir),
      .gen_call(gen_call), .ext10_flag(ext10_flag),
      .rx_data(rx_data), .rx_valid(rx_valid));

   always @(negedge clk) begin
      if (rx_valid) begin
         got[n_valid % 16] = rx_data;
         n_valid++;
      end
      if (addr_hit) n_hit++;
   end

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_start();
      sda_m = 1'b1; scl_m = 1'b1; wclk(4);
      sda_m = 1'b0; wclk(8);
      scl_m = 1'b0; wclk(4);
   endtask

   task automatic do_rstart();
      wclk(4); sda_m = 1'b1; wclk(4);
      scl_m = 1'b1; wclk(8);
      sda_m = 1'b0; wclk(8);
      scl_m = 1'b0; wclk(4);
   endtask

   task automatic do_stop();
      wclk(4); sda_m = 1'b0; wclk(4);
      scl_m = 1'b1; wclk(8);
      sda_m = 1'b1; wclk(8);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack_line);
      for (int i = 7; i >= 0; i--) begin
         wclk(4); sda_m = b[i]; wclk(4);
         scl_m = 1'b1; wclk(8);
         scl_m = 1'b0;
      end
      wclk(4); sda_m = 1'b1; wclk(4);
      scl_m = 1'b1; wclk(4);
      ack_line = sda_line;
      wclk(4);
      scl_m = 1'b0;
   endtask

   initial begin
      wclk(150000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic ack;
      int v0, h0;
      wclk(3);
      rst_n = 1'b1;
      wclk(4);
      // R11 reset state
      check("R11 bus_busy", bus_busy, 0);
      check("R11 sda_pull", sda_pull, 0);
      check("R11 rx_valid", rx_valid, 0);
      check("R11 addr_hit", addr_hit, 0);
      check("R11 flags", {gen_call, ext10_flag, rw_dir}, 0);

      for (int k = 0; k < 7; k++) begin
         logic [20:0] e;
         e = VEC[k];
         gc_en = e[4];
         wclk(2);
         v0 = n_valid; h0 = n_hit;
         do_start();
         check("R1 busy after start", bus_busy, 1);
         send_byte(e[20:13], ack);
         // R3 R5 R6 R7: ack is a low line in the ninth pulse
         check("R3/R5/R6/R7 address ack", ack, !e[3]);
         check("R3 addr_hit count", n_hit - h0, e[3]);
         check("R5 gen_call", gen_call, e[2]);
         check("R7 ext10_flag", ext10_flag, e[1]);
         if (e[3]) check("R3 rw_dir", rw_dir, e[0]);
         send_byte(e[12:5], ack);
         // R8 data ack; R10 no pull in read
         check("R8/R10 data ack", ack, !(e[3] && !e[0]));
         check("R8/R10 rx_valid count", n_valid - v0, (e[3] && !e[0]) ? 1 : 0);
         if (e[3] && !e[0]) check("R8 rx_data", got[v0 % 16], e[12:5]);
         do_stop();
         check("R2 idle after stop", bus_busy, 0);
      end

      // R9 repeated start after a rejected address, then multi-byte write
      gc_en = 1'b0;
      wclk(2);
      v0 = n_valid; h0 = n_hit;
      do_start();
      send_byte(8'h22, ack);
      check("R9 foreign address nack", ack, 1);
      do_rstart();
      check("R9 busy kept", bus_busy, 1);
      send_byte(8'hA4, ack);
      check("R9 address ack after restart", ack, 0);
      check("R9 hit count", n_hit - h0, 1);
      send_byte(8'h3C, ack);
      check("R8 first byte ack", ack, 0);
      send_byte(8'hC3, ack);
      check("R8 second byte ack", ack, 0);
      send_byte(8'h00, ack);
      check("R8 third byte ack", ack, 0);
      check("R8 byte count", n_valid - v0, 3);
      check("R8 byte 0", got[v0 % 16], 8'h3C);
      check("R8 byte 1", got[(v0+1) % 16], 8'hC3);
      check("R8 byte 2", got[(v0+2) % 16], 8'h00);
      do_stop();
      check("R2 busy cleared", bus_busy, 0);
      check("R2 no pull idle", sda_pull, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule